// File: doc/BRIEF.md
# Auto-Precharge Cross-Bank Spacing Checker

This block watches the decoded command stream of a DDR SDRAM controller and enforces the spacing rule that applies after a column command with auto-precharge. When a read or write with auto-precharge is issued, the block remembers its kind, its bank and how many clocks have passed since. Every later command aimed at a *different* bank is compared against the minimum gap for that pair of command kinds. A violation pulse is raised when the command comes too soon.

The gaps depend on the burst length, the CAS latency and the write-to-read turnaround, all supplied as static configuration inputs. The CAS latency is given in half-clock units so that fractional latencies such as 2.5 can be expressed; it is rounded up to whole clocks where it enters a gap. Three ready flags, one per command class, tell a scheduler whether a command of that class to another bank would be legal in the current cycle. Commands to the bank of the recorded auto-precharge are outside this checker's concern and are never flagged.

Top module: `apx_ap_gap_checker`

## Requirements
- R1: While reset is asserted, and after it until the first read or write with auto-precharge, all three ready flags are high and the violation output is low; reset forgets any recorded auto-precharge.
- R2: After a read with auto-precharge, a read or read-with-auto-precharge to another bank is legal no sooner than BL/2 clocks later (BL/2 rounded down).
- R3: After a read with auto-precharge, a write or write-with-auto-precharge to another bank is legal no sooner than ceil(CL) + BL/2 clocks later, where CL is given in half clocks and ceil(CL) = (cas_half_i + 1) / 2, rounded down.
- R4: After a write with auto-precharge, a read or read-with-auto-precharge to another bank is legal no sooner than 1 + BL/2 + tWTR clocks later.
- R5: After a write with auto-precharge, a write or write-with-auto-precharge to another bank is legal no sooner than BL/2 clocks later.
- R6: An activate or precharge to another bank needs only a 1-clock gap. It is therefore never flagged, and its ready flag is always high.
- R7: A command whose bank equals the recorded bank never produces a violation.
- R8: Each new read or write with auto-precharge is first judged against the previous record as an ordinary read or write, and then replaces that record.
- R9: Command encoding on cmd_i: 0 no-op, 1 read, 2 read with auto-precharge, 3 write, 4 write with auto-precharge, 5 activate, 6 precharge, 7 other (treated as no-op). An early command produces viol_o high for exactly one cycle, in the cycle after the one in which it was presented. No-op codes never produce a violation.
- R10: In every cycle, each ready flag is high exactly when a command of its class presented in that cycle to a bank other than the recorded one would not be flagged. Here the elapsed count is the number of clocks since the recorded command was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command code (encoding in R9) |
| bank_i | input | BANK_W | Bank address of the command |
| burst_len_i | input | BL_W | Burst length in data beats |
| cas_half_i | input | CL_W | CAS latency in half clocks |
| wtr_i | input | WTR_W | Write-to-read turnaround in clocks |
| viol_o | output | 1 | One-cycle pulse: the previous cycle's command came too early |
| rdy_rd_o | output | 1 | A read-class command to another bank is legal now |
| rdy_wr_o | output | 1 | A write-class command to another bank is legal now |
| rdy_pa_o | output | 1 | An activate or precharge to another bank is legal now |

## Verification
The assertions assume that burst length, CAS latency and turnaround are held constant from reset onward. They also assume that the burst length is at least 2, so that a write with auto-precharge always blocks reads in the clock that follows it. The stimulus obeys this by changing these inputs only while reset is held, and by using burst lengths of 2, 4 and 8. Commands and banks are otherwise unconstrained. Directed probes place commands at every distance up to and past each gap, on both foreign and matching banks, and random traffic mixes auto-precharge commands densely so that records are replaced often.

// File: rtl/apx_pkg.sv
package apx_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_RD    = 3'd1,
    CMD_RDA   = 3'd2,
    CMD_WR    = 3'd3,
    CMD_WRA   = 3'd4,
    CMD_ACT   = 3'd5,
    CMD_PRE   = 3'd6,
    CMD_OTHER = 3'd7
  } apx_cmd_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_RD   = 2'd1,
    CLS_WR   = 2'd2,
    CLS_PA   = 2'd3
  } apx_cls_e;

  localparam int NUM_CLS = 3;

  function automatic apx_cls_e classify(apx_cmd_e c);
    case (c)
      CMD_RD, CMD_RDA:   return CLS_RD;
      CMD_WR, CMD_WRA:   return CLS_WR;
      CMD_ACT, CMD_PRE:  return CLS_PA;
      default:           return CLS_NONE;
    endcase
  endfunction

  function automatic int half_burst(int bl);
    return bl / 2;
  endfunction

  function automatic int cas_ceil(int cas_half);
    return (cas_half + 1) / 2;
  endfunction

  // index 0 = read class, 1 = write class, 2 = activate/precharge class
  function automatic int gap_after(bit prev_wr, int cls_idx, int bl, int cas_half, int wtr);
    if (cls_idx == 2) return 1;
    if (prev_wr) begin
      if (cls_idx == 0) return 1 + half_burst(bl) + wtr;
      return half_burst(bl);
    end
    if (cls_idx == 0) return half_burst(bl);
    return cas_ceil(cas_half) + half_burst(bl);
  endfunction

endpackage

// File: rtl/apx_ap_record.sv
module apx_ap_record #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_load,
  input  logic              ap_is_wr,
  input  logic [BANK_W-1:0] ap_bank,
  output logic              rec_valid,
  output logic              rec_is_wr,
  output logic [BANK_W-1:0] rec_bank,
  output logic [CNT_W-1:0]  elapsed
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_is_wr <= 1'b0;
      rec_bank  <= '0;
      elapsed   <= '0;
    end else if (ap_load) begin
      rec_valid <= 1'b1;
      rec_is_wr <= ap_is_wr;
      rec_bank  <= ap_bank;
      elapsed   <= CNT_ONE;
    end else if (rec_valid && elapsed != CNT_MAX) begin
      elapsed   <= elapsed + CNT_ONE;
    end
  end

endmodule

// File: rtl/apx_gap_table.sv
module apx_gap_table
  import apx_pkg::*;
#(
  parameter int BL_W  = 4,
  parameter int CL_W  = 4,
  parameter int WTR_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             rec_is_wr,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [CL_W-1:0]  cas_half,
  input  logic [WTR_W-1:0] wtr,
  output logic [CNT_W-1:0] gap [NUM_CLS]
);

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    assign gap[g] = CNT_W'(gap_after(rec_is_wr, g, int'(burst_len),
                                     int'(cas_half), int'(wtr)));
  end

endmodule

// File: rtl/apx_judge.sv
module apx_judge
  import apx_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  apx_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              rec_valid,
  input  logic [BANK_W-1:0] rec_bank,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic [CNT_W-1:0]  gap [NUM_CLS],
  output logic [NUM_CLS-1:0] ready,
  output logic              early,
  output logic              viol
);

  apx_cls_e cls;
  logic     other_bank;
  logic     cls_ready;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_rdy
    assign ready[g] = !rec_valid || (elapsed >= gap[g]);
  end

  assign cls        = classify(cmd);
  assign other_bank = rec_valid && (bank != rec_bank);

  always_comb begin
    case (cls)
      CLS_RD:  cls_ready = ready[0];
      CLS_WR:  cls_ready = ready[1];
      CLS_PA:  cls_ready = ready[2];
      default: cls_ready = 1'b1;
    endcase
  end

  assign early = other_bank && !cls_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= early;
  end

endmodule

// File: rtl/apx_ap_gap_checker.sv
module apx_ap_gap_checker
  import apx_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int BL_W   = 4,
  parameter int CL_W   = 4,
  parameter int WTR_W  = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BL_W-1:0]   burst_len_i,
  input  logic [CL_W-1:0]   cas_half_i,
  input  logic [WTR_W-1:0]  wtr_i,
  output logic              viol_o,
  output logic              rdy_rd_o,
  output logic              rdy_wr_o,
  output logic              rdy_pa_o
);

  apx_cmd_e            cmd;
  logic                ap_load;
  logic                ap_is_wr;
  logic                rec_valid;
  logic                rec_is_wr;
  logic [BANK_W-1:0]   rec_bank;
  logic [CNT_W-1:0]    elapsed;
  logic [CNT_W-1:0]    gap [NUM_CLS];
  logic [NUM_CLS-1:0]  ready;
  logic                early;

  assign cmd      = apx_cmd_e'(cmd_i);
  assign ap_load  = (cmd == CMD_RDA) || (cmd == CMD_WRA);
  assign ap_is_wr = (cmd == CMD_WRA);

  apx_ap_record #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_record (
    .clk       (clk),
    .rst_n     (rst_n),
    .ap_load   (ap_load),
    .ap_is_wr  (ap_is_wr),
    .ap_bank   (bank_i),
    .rec_valid (rec_valid),
    .rec_is_wr (rec_is_wr),
    .rec_bank  (rec_bank),
    .elapsed   (elapsed)
  );

  apx_gap_table #(.BL_W(BL_W), .CL_W(CL_W), .WTR_W(WTR_W), .CNT_W(CNT_W)) u_table (
    .rec_is_wr (rec_is_wr),
    .burst_len (burst_len_i),
    .cas_half  (cas_half_i),
    .wtr       (wtr_i),
    .gap       (gap)
  );

  apx_judge #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bank      (bank_i),
    .rec_valid (rec_valid),
    .rec_bank  (rec_bank),
    .elapsed   (elapsed),
    .gap       (gap),
    .ready     (ready),
    .early     (early),
    .viol      (viol_o)
  );

  assign rdy_rd_o = ready[0];
  assign rdy_wr_o = ready[1];
  assign rdy_pa_o = ready[2];

endmodule

// File: rtl/apx_gap_sva.sv
module apx_gap_sva #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              rec_valid,
  input logic [BANK_W-1:0] rec_bank,
  input logic              viol_o,
  input logic              rdy_rd_o,
  input logic              rdy_wr_o,
  input logic              rdy_pa_o
);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> (rdy_rd_o && rdy_wr_o && rdy_pa_o));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> !viol_o);

  p_wra_blocks_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4) |=> !rdy_rd_o);

  p_pa_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd5 || cmd_i == 3'd6) |=> !viol_o);

  p_pa_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pa_o);

  p_same_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && bank_i == rec_bank) |=> !viol_o);

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0 || cmd_i == 3'd7) |=> !viol_o);

  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && bank_i != rec_bank &&
     (((cmd_i == 3'd1 || cmd_i == 3'd2) && !rdy_rd_o) ||
      ((cmd_i == 3'd3 || cmd_i == 3'd4) && !rdy_wr_o))) |=> viol_o);

  p_ready_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rdy_wr_o && cmd_i != 3'd2 && cmd_i != 3'd4) |=> rdy_wr_o);

endmodule

bind apx_ap_gap_checker apx_gap_sva #(.BANK_W(BANK_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_i     (cmd_i),
  .bank_i    (bank_i),
  .rec_valid (rec_valid),
  .rec_bank  (rec_bank),
  .viol_o    (viol_o),
  .rdy_rd_o  (rdy_rd_o),
  .rdy_wr_o  (rdy_wr_o),
  .rdy_pa_o  (rdy_pa_o)
);

// File: tb/apx_ap_gap_checker_test.sv
module apx_ap_gap_checker_test;

  localparam int BANK_W = 2;
  localparam time CLK_P = 20ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cmd_i = 3'd0;
  logic [BANK_W-1:0] bank_i = '0;
  logic [3:0]        burst_len_i = 4'd8;
  logic [3:0]        cas_half_i = 4'd5;
  logic [2:0]        wtr_i = 3'd2;
  logic viol_o, rdy_rd_o, rdy_wr_o, rdy_pa_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit have_ap;
  bit ap_wr;
  int ap_bank;
  int ap_cycle;
  int cyc;
  bit exp_viol;
  string exp_tag;

  always #(CLK_P/2) clk = ~clk;

  apx_ap_gap_checker uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
    .burst_len_i(burst_len_i), .cas_half_i(cas_half_i), .wtr_i(wtr_i),
    .viol_o(viol_o), .rdy_rd_o(rdy_rd_o), .rdy_wr_o(rdy_wr_o), .rdy_pa_o(rdy_pa_o)
  );

  task automatic check(string tag, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, actual, expected, cyc);
    end
  endtask

  // command kind: 0 read-ish, 1 write-ish, 2 act/pre, -1 nothing
  function automatic int kind_of(int c);
    if (c == 1 || c == 2) return 0;
    if (c == 3 || c == 4) return 1;
    if (c == 5 || c == 6) return 2;
    return -1;
  endfunction

  function automatic int min_gap(bit wr, int k);
    int hb = int'(burst_len_i) >> 1;
    if (k == 2) return 1;
    if (wr && k == 0) return 1 + hb + int'(wtr_i);
    if (wr) return hb;
    if (k == 0) return hb;
    return ((int'(cas_half_i) + 1) >> 1) + hb;
  endfunction

  function automatic string req_of(bit wr, int k);
    if (k == 2) return "R6";
    if (!wr && k == 0) return "R2";
    if (!wr) return "R3";
    if (k == 0) return "R4";
    return "R5";
  endfunction

  function automatic bit model_ready(int k);
    if (!have_ap) return 1'b1;
    return (cyc - ap_cycle) >= min_gap(ap_wr, k);
  endfunction

  task automatic step(int c, int b);
    int k;
    @(negedge clk);
    check("R10 rd-ready", rdy_rd_o, model_ready(0));
    check("R10 wr-ready", rdy_wr_o, model_ready(1));
    check("R6 pa-ready", rdy_pa_o, model_ready(2));
    check({exp_tag, " R9 viol"}, viol_o, exp_viol);
    cmd_i  = 3'(c);
    bank_i = BANK_W'(b);
    k = kind_of(c);
    if (k < 0) begin
      exp_viol = 0; exp_tag = "R9 nop";
    end else if (!have_ap) begin
      exp_viol = 0; exp_tag = "R1 idle";
    end else if (b == ap_bank) begin
      exp_viol = 0; exp_tag = "R7 same-bank";
    end else begin
      exp_viol = !model_ready(k);
      exp_tag = req_of(ap_wr, k);
      if (c == 2 || c == 4) exp_tag = {exp_tag, " R8"};
    end
    if (c == 2 || c == 4) begin
      have_ap = 1; ap_wr = (c == 4); ap_bank = b; ap_cycle = cyc;
    end
    cyc++;
  endtask

  task automatic do_reset(int bl, int clh, int w);
    @(negedge clk);
    rst_n = 0; cmd_i = 3'd0; bank_i = '0;
    burst_len_i = 4'(bl); cas_half_i = 4'(clh); wtr_i = 3'(w);
    repeat (2) begin
      @(negedge clk);
      check("R1 reset rd-ready", rdy_rd_o, 1'b1);
      check("R1 reset wr-ready", rdy_wr_o, 1'b1);
      check("R1 reset pa-ready", rdy_pa_o, 1'b1);
      check("R1 reset viol", viol_o, 1'b0);
    end
    rst_n = 1;
    have_ap = 0; exp_viol = 0; exp_tag = "R1 post-reset"; cyc = 0; ap_cycle = 0;
  endtask

  task automatic probe(int ap_cmd, int probe_cmd, int probe_bank);
    step(ap_cmd, 0);
    for (int d = 1; d <= 18; d++) step(probe_cmd, probe_bank);
    step(0, 0);
  endtask

  task automatic run_config(int bl, int clh, int w);
    do_reset(bl, clh, w);
    for (int i = 0; i < 4; i++) step(1 + (i % 6), i % 4);
    for (int a = 0; a < 2; a++) begin
      for (int p = 1; p <= 6; p++) begin
        probe(a == 0 ? 2 : 4, p, 1 + (p % 3));
        // separate single probe at each distance so records are not replaced
        for (int d = 1; d <= 16; d++) begin
          step(a == 0 ? 2 : 4, 2);
          for (int z = 1; z < d; z++) step(0, 0);
          step(p, 3);
        end
      end
      probe(a == 0 ? 2 : 4, 3, 0);   // same bank R7
    end
    for (int i = 0; i < 600; i++) step($urandom_range(0, 7), $urandom_range(0, 3));
    // reset clears a pending write record (R1)
    step(4, 1);
    do_reset(bl, clh, w);
    step(1, 2);
    step(0, 0);
    step(0, 0);
  endtask

  initial begin
    run_config(8, 5, 2);
    run_config(4, 6, 1);
    run_config(2, 3, 0);
    run_config(8, 4, 7);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule